// File: doc/BRIEF.md
# Serial Reconfiguration Control Register

This block is the serial access port of a remote-upgrade controller. A dedicated serial clock drives two registers of equal width. The first is a shift register that is reached bit by bit through a serial input and a serial output. The second is a held word that software or a remote host fills by shifting in a value and then committing it. Two mode inputs select one of three actions on each rising edge. In serial mode the shift register moves one place toward its least significant end. In capture mode the shift register loads a status word in parallel. In commit mode the held word copies the shift register. A feature-enable input freezes the whole port while it is low.

The block also conditions two asynchronous, active-low requests. The first is a timer-kick input. It produces a one-cycle watchdog-clear strobe only after it has stayed low for a qualifying time of at least 250 ns, which is converted into serial-clock cycles from a clock-period parameter. The second is a reconfigure request. After a two-stage synchronizer, its high-to-low transition gives a single one-cycle reconfiguration strobe. The watchdog counter, the configuration engine and the flash access sit outside this block. The block sees them only through the status bus and the two strobes.

Top module: `rcsu_port`

## Requirements
- R1: While rstN is low, heldWord, serOut, wdClear and reconfPulse are all 0, and the shift register is cleared to 0.
- R2: With upgradeEn high and shiftSel high, each rising edge moves the shift register one bit toward bit 0 and places serIn in the most significant bit. capSel has no effect in this mode.
- R3: serOut always shows bit 0 of the shift register, so a word leaves the port least significant bit first, one bit per edge in serial mode.
- R4: With upgradeEn high, shiftSel low and capSel low, a rising edge copies the shift register into heldWord, and the shift register keeps its value.
- R5: With upgradeEn high, shiftSel low and capSel high, a rising edge loads statusWord into the shift register, and heldWord keeps its value.
- R6: With upgradeEn low, neither register changes, and wdClear and reconfPulse stay 0, whatever the mode, data and request inputs do.
- R7: The timer-kick input must be low at MIN_CYC consecutive rising edges, where MIN_CYC = ceil(250 ns / clock period), which is 13 at 20 ns. When it is, wdClear goes high for exactly one cycle, after edge MIN_CYC+2 counted from the first low edge. A shorter low period gives no pulse. Holding the input low longer gives no second pulse.
- R8: A falling edge on reconfN gives exactly one single-cycle reconfPulse, visible after the third rising edge at which the input is low. Holding reconfN low does not repeat the strobe, and a rising edge gives none.
- R9: The two strobes and the register actions are independent. wdClear and reconfPulse may be high in the same cycle while the shift register keeps shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all actions on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| upgradeEn | input | 1 | Feature enable; the port is frozen while low |
| shiftSel | input | 1 | High selects serial mode |
| capSel | input | 1 | With shiftSel low: high = capture, low = commit |
| serIn | input | 1 | Serial data entering at the MSB |
| serOut | output | 1 | Serial data, LSB of the shift register |
| statusWord | input | WIDTH | Parallel status captured in capture mode |
| heldWord | output | WIDTH | Committed word |
| timerRstN | input | 1 | Active-low watchdog kick request, asynchronous |
| wdClear | output | 1 | One-cycle watchdog-clear strobe |
| reconfN | input | 1 | Active-low reconfigure request, asynchronous |
| reconfPulse | output | 1 | One-cycle reconfiguration strobe |

## Verification
The watchdog-clear strobe and the reconfiguration strobe have different latencies: MIN_CYC+2 edges for the kick and 3 edges for the reconfigure request. The bench therefore pulls the kick input low and, 12 edges later, pulls the reconfigure input low, so both strobes are due after the fifteenth edge. This is done while serial mode keeps moving data. The run passes only if both strobes are seen in that same sampled cycle. The serial stream must also stay in step with the bench's own model of the shift register.

// File: rtl/rcsu_pkg.sv
package rcsu_pkg;

  typedef struct packed {
    logic doShift;
    logic doCapture;
    logic doUpdate;
  } rcsu_strobe_t;

  function automatic int cyclesFor(input int lowNs, input int periodPs);
    return (lowNs * 1000 + periodPs - 1) / periodPs;
  endfunction

endpackage

// File: rtl/rcsu_sync.sv
module rcsu_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= RESET_VAL;
        else       chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= {STAGES{RESET_VAL}};
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/rcsu_ctrl.sv
module rcsu_ctrl
  import rcsu_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 20000,
  parameter int MIN_LOW_NS    = 250,
  parameter int SYNC_STAGES   = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         upgradeEn,
  input  logic         shiftSel,
  input  logic         capSel,
  input  logic         timerRstN,
  input  logic         reconfN,
  output rcsu_strobe_t strobes,
  output logic         wdClear,
  output logic         reconfPulse
);

  localparam int MIN_CYC = (cyclesFor(MIN_LOW_NS, CLK_PERIOD_PS) < 1) ? 1
                           : cyclesFor(MIN_LOW_NS, CLK_PERIOD_PS);
  localparam int CNT_W   = $clog2(MIN_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(MIN_CYC);
  localparam logic [CNT_W-1:0] CNT_FIRE = CNT_W'(MIN_CYC - 1);

  logic timerSynced;
  logic reconfSynced;
  logic reconfPrev;
  logic [CNT_W-1:0] lowCnt;

  rcsu_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_timerSync (
    .clk (clk), .rstN (rstN), .din (timerRstN), .dout (timerSynced)
  );

  rcsu_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_reconfSync (
    .clk (clk), .rstN (rstN), .din (reconfN), .dout (reconfSynced)
  );

  // Mode decode: serial mode wins; capSel only matters when shiftSel is low.
  always_comb begin
    strobes           = '0;
    strobes.doShift   = upgradeEn &  shiftSel;
    strobes.doCapture = upgradeEn & ~shiftSel &  capSel;
    strobes.doUpdate  = upgradeEn & ~shiftSel & ~capSel;
  end

  // Low-time qualifier: counts consecutive low samples, saturating at the top.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt  <= '0;
      wdClear <= 1'b0;
    end else begin
      if (timerSynced)           lowCnt <= '0;
      else if (lowCnt != CNT_TOP) lowCnt <= lowCnt + 1'b1;
      wdClear <= upgradeEn && !timerSynced && (lowCnt == CNT_FIRE);
    end
  end

  // Falling-edge detector on the synchronized reconfigure request.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reconfPrev  <= 1'b1;
      reconfPulse <= 1'b0;
    end else begin
      reconfPrev  <= reconfSynced;
      reconfPulse <= upgradeEn && reconfPrev && !reconfSynced;
    end
  end

  p_wd_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    wdClear |=> !wdClear);

  p_wd_needs_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    wdClear |-> $past(!timerSynced));

  p_reconf_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    reconfPulse |=> !reconfPulse);

  p_reconf_gated_r6: assert property (@(posedge clk) disable iff (!rstN)
    reconfPulse |-> $past(upgradeEn));

  p_wd_gated_r6: assert property (@(posedge clk) disable iff (!rstN)
    wdClear |-> $past(upgradeEn));

endmodule

// File: rtl/rcsu_datapath.sv
module rcsu_datapath
  import rcsu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  rcsu_strobe_t     strobes,
  input  logic             serIn,
  input  logic [WIDTH-1:0] statusWord,
  output logic             serOut,
  output logic [WIDTH-1:0] shiftWord,
  output logic [WIDTH-1:0] heldWord
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftWord <= '0;
    end else if (strobes.doShift) begin
      shiftWord <= {serIn, shiftWord[WIDTH-1:1]};
    end else if (strobes.doCapture) begin
      shiftWord <= statusWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 heldWord <= '0;
    else if (strobes.doUpdate) heldWord <= shiftWord;
  end

  assign serOut = shiftWord[0];

  p_shift_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doShift |=> shiftWord == {$past(serIn), $past(shiftWord[WIDTH-1:1])});

  p_update_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doUpdate |=> (heldWord == $past(shiftWord)) && $stable(shiftWord));

  p_capture_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doCapture |=> (shiftWord == $past(statusWord)) && $stable(heldWord));

endmodule

// File: rtl/rcsu_port.sv
module rcsu_port
  import rcsu_pkg::*;
#(
  parameter int WIDTH         = 32,
  parameter int CLK_PERIOD_PS = 20000,
  parameter int MIN_LOW_NS    = 250,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             upgradeEn,
  input  logic             shiftSel,
  input  logic             capSel,
  input  logic             serIn,
  output logic             serOut,
  input  logic [WIDTH-1:0] statusWord,
  output logic [WIDTH-1:0] heldWord,
  input  logic             timerRstN,
  output logic             wdClear,
  input  logic             reconfN,
  output logic             reconfPulse
);

  rcsu_strobe_t     strobes;
  logic [WIDTH-1:0] shiftWord;

  rcsu_ctrl #(
    .CLK_PERIOD_PS (CLK_PERIOD_PS),
    .MIN_LOW_NS    (MIN_LOW_NS),
    .SYNC_STAGES   (SYNC_STAGES)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .upgradeEn   (upgradeEn),
    .shiftSel    (shiftSel),
    .capSel      (capSel),
    .timerRstN   (timerRstN),
    .reconfN     (reconfN),
    .strobes     (strobes),
    .wdClear     (wdClear),
    .reconfPulse (reconfPulse)
  );

  rcsu_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .serIn      (serIn),
    .statusWord (statusWord),
    .serOut     (serOut),
    .shiftWord  (shiftWord),
    .heldWord   (heldWord)
  );

  p_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    !upgradeEn |=> $stable(shiftWord) && $stable(heldWord));

endmodule

// File: tb/sim_rcsu_port.sv
module sim_rcsu_port;

  localparam int W = 8;
  localparam int MIN_CYC = 13;

  logic clk = 1'b0;
  logic rstN, upgradeEn, shiftSel, capSel, serIn, timerRstN, reconfN;
  logic [W-1:0] statusWord;
  logic serOut, wdClear, reconfPulse;
  logic [W-1:0] heldWord;

  int checks = 0, errors = 0;
  int tickNo = 0, wdCount = 0, rcCount = 0, wdFirst = 0, rcFirst = 0;
  logic [W-1:0] mShift = '0, mHeld = '0;
  bit done = 0;

  always #10 clk = ~clk;

  rcsu_port #(.WIDTH(W), .CLK_PERIOD_PS(20000), .MIN_LOW_NS(250), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rstN(rstN), .upgradeEn(upgradeEn), .shiftSel(shiftSel), .capSel(capSel),
    .serIn(serIn), .serOut(serOut), .statusWord(statusWord), .heldWord(heldWord),
    .timerRstN(timerRstN), .wdClear(wdClear), .reconfN(reconfN), .reconfPulse(reconfPulse)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clearCounts();
    tickNo = 0; wdCount = 0; rcCount = 0; wdFirst = 0; rcFirst = 0;
  endtask

  task automatic tick();
    if (upgradeEn) begin
      if (shiftSel)    mShift = {serIn, mShift[W-1:1]};
      else if (capSel) mShift = statusWord;
      else             mHeld  = mShift;
    end
    @(posedge clk);
    #5;
    tickNo++;
    if (wdClear) begin wdCount++; if (wdFirst == 0) wdFirst = tickNo; end
    if (reconfPulse) begin rcCount++; if (rcFirst == 0) rcFirst = tickNo; end
    chk(serOut == mShift[0], "R3", "serOut vs model", serOut, mShift[0]);
    chk(heldWord == mHeld, "R4", "heldWord vs model", heldWord, mHeld);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 0; upgradeEn = 1; shiftSel = 0; capSel = 1; serIn = 0;
    statusWord = 8'hA5; timerRstN = 1; reconfN = 1;
    repeat (3) @(posedge clk);
    #5;
    // R1: reset state
    chk(heldWord == 0, "R1", "heldWord in reset", heldWord, 0);
    chk(serOut == 0, "R1", "serOut in reset", serOut, 0);
    chk(wdClear == 0 && reconfPulse == 0, "R1", "strobes in reset", wdClear | reconfPulse, 0);
    rstN = 1;

    // R5, R4, R3, R2: every status word captured, committed, shifted out and replaced
    for (int v = 0; v < 256; v++) begin
      statusWord = v[W-1:0];
      shiftSel = 0; capSel = 1; tick();
      capSel = 0; tick();
      chk(heldWord == v[W-1:0], "R5", "capture then commit", heldWord, v);
      shiftSel = 1;
      for (int b = 0; b < W; b++) begin
        capSel = v[b];
        serIn = ~v[b];
        chk(serOut == v[b], "R3", "serial order LSB first", serOut, v[b]);
        tick();
      end
      shiftSel = 0; capSel = 0; tick();
      chk(heldWord == ~v[W-1:0], "R2", "shifted-in word", heldWord, (~v) & 8'hFF);
    end

    // R6: frozen while disabled
    statusWord = 8'h3C; shiftSel = 0; capSel = 1; tick();
    for (int m = 0; m < 4; m++) begin
      upgradeEn = 0; shiftSel = m[1]; capSel = m[0]; serIn = m[0]; statusWord = 8'hC3;
      tick(); tick();
      chk(heldWord == mHeld && serOut == mShift[0], "R6", "no change while disabled", heldWord, mHeld);
    end
    upgradeEn = 1; shiftSel = 0; capSel = 0; tick();
    chk(heldWord == 8'h3C, "R6", "shift register untouched while disabled", heldWord, 8'h3C);
    upgradeEn = 0; clearCounts();
    timerRstN = 0; reconfN = 0;
    repeat (20) tick();
    timerRstN = 1; reconfN = 1;
    repeat (6) tick();
    chk(wdCount == 0, "R6", "no watchdog strobe while disabled", wdCount, 0);
    chk(rcCount == 0, "R6", "no reconfigure strobe while disabled", rcCount, 0);
    upgradeEn = 1; shiftSel = 0; capSel = 1; statusWord = 8'h5A;

    // R7: sweep of low durations around the qualifying time
    for (int d = 1; d <= 20; d++) begin
      clearCounts();
      timerRstN = 0;
      repeat (d) tick();
      timerRstN = 1;
      repeat (20) tick();
      chk(wdCount == ((d >= MIN_CYC) ? 1 : 0), "R7", $sformatf("pulse count low=%0d", d),
          wdCount, (d >= MIN_CYC) ? 1 : 0);
      if (d >= MIN_CYC)
        chk(wdFirst == MIN_CYC + 2, "R7", "pulse latency", wdFirst, MIN_CYC + 2);
    end

    // R8: reconfigure falling edge, held low, then release
    clearCounts();
    reconfN = 0;
    repeat (10) tick();
    chk(rcCount == 1, "R8", "one strobe for held low", rcCount, 1);
    chk(rcFirst == 3, "R8", "strobe latency", rcFirst, 3);
    reconfN = 1;
    repeat (6) tick();
    chk(rcCount == 1, "R8", "no strobe on rising edge", rcCount, 1);

    // R9: both strobes in the same cycle while shifting
    clearCounts();
    shiftSel = 1; serIn = 1;
    timerRstN = 0;
    repeat (12) tick();
    reconfN = 0;
    repeat (8) tick();
    chk(wdFirst == 15, "R9", "watchdog strobe cycle", wdFirst, 15);
    chk(rcFirst == 15, "R9", "reconfigure strobe cycle", rcFirst, 15);
    chk(wdCount == 1 && rcCount == 1, "R9", "one of each strobe", wdCount + rcCount, 2);
    timerRstN = 1; reconfN = 1; shiftSel = 0; capSel = 0; tick();
    chk(heldWord == 8'hFF, "R9", "shifting continued", heldWord, 8'hFF);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule